// File: doc/BRIEF.md
# Memory-Side Stall Buffer Pair

This block sits between a memory controller that never pauses and user logic that can be told to pause. A pause request from the controller reaches the user logic only after a fixed spreading delay. Requests the user logic issues during that delay cannot be sent while the controller is busy, so they are held in a request queue. Read words that the controller returns while the user logic is paused are held in a response queue. Both queues drain oldest first once their side is free again.

When nothing is paused and both queues are empty, requests and read words pass through combinationally, with no added cycle. Each queue is a plain FIFO sized by parameter. A write into a full queue that is not also being read in the same cycle is discarded and raises a sticky error flag.

Top module: `stall_buffer_pair`

## Requirements
- R1: After reset `mem_req_vld`, `usr_rsp_vld`, `usr_stall` and `ovf_err` are 0 and both queues are empty.
- R2: `usr_stall` equals `mem_stall` delayed by exactly `STALL_DLY` clock cycles (2 by default).
- R3: A request with `mem_stall` low and an empty request queue appears on `mem_req_*` in the same cycle, with `mem_req_we`, address and write data unchanged.
- R4: A request made while `mem_stall` is high or the request queue holds entries is queued, and `mem_req_vld` is never high while `mem_stall` is high.
- R5: While `mem_stall` is low and the request queue holds entries, one queued request is issued per cycle, oldest first, and any new request goes in behind them.
- R6: A read word with `usr_stall` low and an empty response queue appears on `usr_rsp_*` in the same cycle.
- R7: A read word arriving while `usr_stall` is high or the response queue holds entries is queued, and `usr_rsp_vld` is never high while `usr_stall` is high.
- R8: While `usr_stall` is low and the response queue holds entries, one word is delivered per cycle, oldest first, and new arrivals go in behind them.
- R9: A write into a full queue with no read from it in that cycle is dropped, the queue keeps its earlier contents, and `ovf_err` rises on the next cycle and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_stall | input | 1 | Controller busy, cannot take a request this cycle |
| usr_stall | output | 1 | Pause seen by user logic, `mem_stall` delayed |
| usr_req_vld | input | 1 | User request valid |
| usr_req_we | input | 1 | User request is a write |
| usr_req_addr | input | AW | User request address |
| usr_req_wdata | input | DW | User write data |
| mem_req_vld | output | 1 | Request to controller valid |
| mem_req_we | output | 1 | Request to controller is a write |
| mem_req_addr | output | AW | Request address to controller |
| mem_req_wdata | output | DW | Write data to controller |
| mem_rsp_vld | input | 1 | Read word from controller valid |
| mem_rsp_data | input | DW | Read word from controller |
| usr_rsp_vld | output | 1 | Read word to user valid |
| usr_rsp_data | output | DW | Read word to user |
| ovf_err | output | 1 | Sticky queue overflow flag |

## Verification
Two cases can fall in one cycle. A queued request is replayed while the user issues a new one, and a queued read word is delivered while a new one arrives. The cycle table keeps the user requesting and the controller returning data across the cycle where each pause ends. The checks then require the replayed head on the memory side and the oldest stored word on the user side, in that same cycle. The newcomers must appear only after everything queued before them.

// File: rtl/stall_buffer_pair.sv
module stall_buffer_pair #(
  parameter int AW        = 18,
  parameter int DW        = 128,
  parameter int STALL_DLY = 2,
  parameter int IDEPTH    = 8,
  parameter int ODEPTH    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_stall,
  output logic          usr_stall,
  input  logic          usr_req_vld,
  input  logic          usr_req_we,
  input  logic [AW-1:0] usr_req_addr,
  input  logic [DW-1:0] usr_req_wdata,
  output logic          mem_req_vld,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_vld,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          usr_rsp_vld,
  output logic [DW-1:0] usr_rsp_data,
  output logic          ovf_err
);

  localparam int RQW = 1 + AW + DW;
  localparam int IPW = $clog2(IDEPTH);
  localparam int OPW = $clog2(ODEPTH);
  localparam logic [IPW:0] ICAP = (IPW+1)'(IDEPTH);
  localparam logic [OPW:0] OCAP = (OPW+1)'(ODEPTH);

  // stall spreading line
  logic [STALL_DLY-1:0] sline;
  generate
    if (STALL_DLY == 1) begin : g_d1
      always_ff @(posedge clk)
        if (!rst_n) sline <= '0;
        else        sline <= mem_stall;
    end else begin : g_dn
      always_ff @(posedge clk)
        if (!rst_n) sline <= '0;
        else        sline <= {sline[STALL_DLY-2:0], mem_stall};
    end
  endgenerate
  assign usr_stall = sline[STALL_DLY-1];

  // request queue
  logic [RQW-1:0] imem [IDEPTH];
  logic [IPW-1:0] iwr, ird;
  logic [IPW:0]   icnt;
  logic [RQW-1:0] ireq, ihead;
  logic i_empty, i_full, i_pop, i_byp, i_want, i_push, i_drop;

  assign ireq    = {usr_req_we, usr_req_addr, usr_req_wdata};
  assign ihead   = imem[ird];
  assign i_empty = (icnt == '0);
  assign i_full  = (icnt == ICAP);
  assign i_pop   = !mem_stall && !i_empty;
  assign i_byp   = usr_req_vld && !mem_stall && i_empty;
  assign i_want  = usr_req_vld && !i_byp;
  assign i_push  = i_want && (!i_full || i_pop);
  assign i_drop  = i_want && i_full && !i_pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iwr  <= '0;
      ird  <= '0;
      icnt <= '0;
    end else begin
      if (i_push) begin
        imem[iwr] <= ireq;
        iwr <= (iwr == IPW'(IDEPTH-1)) ? '0 : iwr + 1'b1;
      end
      if (i_pop)
        ird <= (ird == IPW'(IDEPTH-1)) ? '0 : ird + 1'b1;
      icnt <= icnt + (IPW+1)'(i_push) - (IPW+1)'(i_pop);
    end
  end

  logic [RQW-1:0] mreq;
  assign mreq = i_pop ? ihead : (i_byp ? ireq : '0);
  assign mem_req_vld = i_pop || i_byp;
  assign {mem_req_we, mem_req_addr, mem_req_wdata} = mreq;

  // response queue
  logic [DW-1:0]  omem [ODEPTH];
  logic [OPW-1:0] owr, ord;
  logic [OPW:0]   ocnt;
  logic o_empty, o_full, o_pop, o_byp, o_want, o_push, o_drop;

  assign o_empty = (ocnt == '0);
  assign o_full  = (ocnt == OCAP);
  assign o_pop   = !usr_stall && !o_empty;
  assign o_byp   = mem_rsp_vld && !usr_stall && o_empty;
  assign o_want  = mem_rsp_vld && !o_byp;
  assign o_push  = o_want && (!o_full || o_pop);
  assign o_drop  = o_want && o_full && !o_pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owr  <= '0;
      ord  <= '0;
      ocnt <= '0;
    end else begin
      if (o_push) begin
        omem[owr] <= mem_rsp_data;
        owr <= (owr == OPW'(ODEPTH-1)) ? '0 : owr + 1'b1;
      end
      if (o_pop)
        ord <= (ord == OPW'(ODEPTH-1)) ? '0 : ord + 1'b1;
      ocnt <= ocnt + (OPW+1)'(o_push) - (OPW+1)'(o_pop);
    end
  end

  assign usr_rsp_vld  = o_pop || o_byp;
  assign usr_rsp_data = o_pop ? omem[ord] : (o_byp ? mem_rsp_data : '0);

  always_ff @(posedge clk)
    if (!rst_n) ovf_err <= 1'b0;
    else        ovf_err <= ovf_err || i_drop || o_drop;

  a_r4_no_req_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |-> !mem_req_vld);
  a_r7_no_rsp_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    usr_stall |-> !usr_rsp_vld);
  a_r5_replay_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_stall && icnt != '0) |-> mem_req_vld);
  a_r8_drain_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!usr_stall && ocnt != '0) |-> usr_rsp_vld);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (icnt <= ICAP) && (ocnt <= OCAP));

endmodule

// File: tb/tb_stall_buffer_pair.sv
module tb_stall_buffer_pair;
  localparam int AW = 18, DW = 128, DEP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_stall = 0, usr_req_vld = 0, usr_req_we = 0, mem_rsp_vld = 0;
  logic [AW-1:0] usr_req_addr = '0;
  logic [DW-1:0] usr_req_wdata = '0, mem_rsp_data = '0;
  logic usr_stall, mem_req_vld, mem_req_we, usr_rsp_vld, ovf_err;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata, usr_rsp_data;

  always #2 clk = ~clk;

  stall_buffer_pair dut (
    .clk(clk), .rst_n(rst_n), .mem_stall(mem_stall), .usr_stall(usr_stall),
    .usr_req_vld(usr_req_vld), .usr_req_we(usr_req_we), .usr_req_addr(usr_req_addr),
    .usr_req_wdata(usr_req_wdata), .mem_req_vld(mem_req_vld), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_rsp_vld(mem_rsp_vld),
    .mem_rsp_data(mem_rsp_data), .usr_rsp_vld(usr_rsp_vld), .usr_rsp_data(usr_rsp_data),
    .ovf_err(ovf_err));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ms, input logic uv, input logic uw, input logic [7:0] ua,
                       input logic rv, input logic [7:0] rd);
    mem_stall = ms; usr_req_vld = uv; usr_req_we = uw;
    usr_req_addr = {10'b0, ua}; usr_req_wdata = {120'b0, ua};
    mem_rsp_vld = rv; mem_rsp_data = {120'b0, rd};
  endtask

  task automatic do_reset();
    @(negedge clk); drive(0,0,0,8'h00,0,8'h00); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  // {ms,uv,uw,ua,rv,rd, e_mv,e_mw,e_ma,e_us,e_uv,e_ud}
  localparam logic [39:0] VEC [0:15] = '{
    {1'b0,1'b1,1'b1,8'h01,1'b0,8'h00, 1'b1,1'b1,8'h01,1'b0,1'b0,8'h00},
    {1'b1,1'b1,1'b0,8'h02,1'b1,8'hA1, 1'b0,1'b0,8'h00,1'b0,1'b1,8'hA1},
    {1'b1,1'b1,1'b1,8'h03,1'b1,8'hA2, 1'b0,1'b0,8'h00,1'b0,1'b1,8'hA2},
    {1'b1,1'b0,1'b0,8'h00,1'b1,8'hA3, 1'b0,1'b0,8'h00,1'b1,1'b0,8'h00},
    {1'b0,1'b0,1'b0,8'h00,1'b1,8'hA4, 1'b1,1'b0,8'h02,1'b1,1'b0,8'h00},
    {1'b0,1'b1,1'b0,8'h04,1'b0,8'h00, 1'b1,1'b1,8'h03,1'b1,1'b0,8'h00},
    {1'b0,1'b1,1'b0,8'h05,1'b1,8'hA5, 1'b1,1'b0,8'h04,1'b0,1'b1,8'hA3},
    {1'b0,1'b0,1'b0,8'h00,1'b0,8'h00, 1'b1,1'b0,8'h05,1'b0,1'b1,8'hA4},
    {1'b0,1'b1,1'b0,8'h06,1'b0,8'h00, 1'b1,1'b0,8'h06,1'b0,1'b1,8'hA5},
    {1'b0,1'b0,1'b0,8'h00,1'b1,8'hA6, 1'b0,1'b0,8'h00,1'b0,1'b1,8'hA6},
    {1'b1,1'b0,1'b0,8'h00,1'b1,8'hA7, 1'b0,1'b0,8'h00,1'b0,1'b1,8'hA7},
    {1'b0,1'b0,1'b0,8'h00,1'b1,8'hA8, 1'b0,1'b0,8'h00,1'b0,1'b1,8'hA8},
    {1'b0,1'b1,1'b0,8'h07,1'b1,8'hA9, 1'b1,1'b0,8'h07,1'b1,1'b0,8'h00},
    {1'b0,1'b0,1'b0,8'h00,1'b0,8'h00, 1'b0,1'b0,8'h00,1'b0,1'b1,8'hA9},
    {1'b0,1'b0,1'b0,8'h00,1'b0,8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0,8'h00},
    {1'b0,1'b0,1'b0,8'h00,1'b0,8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0,8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk("R1 mem_req_vld", mem_req_vld, 0);
    chk("R1 usr_rsp_vld", usr_rsp_vld, 0);
    chk("R1 usr_stall", usr_stall, 0);
    chk("R1 ovf_err", ovf_err, 0);

    for (int c = 0; c < 16; c++) begin
      logic [39:0] v;
      if (c > 0) @(negedge clk);
      v = VEC[c];
      drive(v[39], v[38], v[37], v[36:29], v[28], v[27:20]);
      #1;
      chk($sformatf("R3,R4,R5 mem_req_vld c%0d", c), mem_req_vld, v[19]);
      if (v[19]) begin
        chk($sformatf("R3,R5 mem_req_we c%0d", c), mem_req_we, v[18]);
        chk($sformatf("R3,R5 mem_req_addr c%0d", c), mem_req_addr, v[17:10]);
        chk($sformatf("R3,R5 mem_req_wdata c%0d", c), mem_req_wdata, v[17:10]);
      end
      chk($sformatf("R2 usr_stall c%0d", c), usr_stall, v[9]);
      chk($sformatf("R6,R7,R8 usr_rsp_vld c%0d", c), usr_rsp_vld, v[8]);
      if (v[8]) chk($sformatf("R6,R8 usr_rsp_data c%0d", c), usr_rsp_data, v[7:0]);
    end
    chk("R9 no overflow in table", ovf_err, 0);

    // request queue overflow
    do_reset();
    for (int k = 1; k <= DEP + 1; k++) begin
      @(negedge clk);
      drive(1, 1, 0, 8'(k), 0, 8'h00);
      #1;
      chk("R4 held while stalled", mem_req_vld, 0);
      chk("R9 no early error", ovf_err, 0);
    end
    @(negedge clk);
    drive(0,0,0,8'h00,0,8'h00);
    #1;
    chk("R9 error raised", ovf_err, 1);
    for (int k = 1; k <= DEP; k++) begin
      if (k > 1) @(negedge clk);
      #1;
      chk("R5 replay valid", mem_req_vld, 1);
      chk("R5,R9 replay order", mem_req_addr, k);
    end
    @(negedge clk); #1;
    chk("R9 dropped request absent", mem_req_vld, 0);
    chk("R9 error sticky", ovf_err, 1);

    // response queue overflow and stall delay
    do_reset();
    @(negedge clk); drive(1,0,0,8'h00,0,8'h00);
    @(negedge clk); #1;
    chk("R2 one cycle after stall", usr_stall, 0);
    @(negedge clk); #1;
    chk("R2 two cycles after stall", usr_stall, 1);
    for (int k = 0; k <= DEP; k++) begin
      if (k > 0) @(negedge clk);
      drive(1, 0, 0, 8'h00, 1, 8'(8'h10 + k));
      #1;
      chk("R7 held while user stalled", usr_rsp_vld, 0);
    end
    @(negedge clk); drive(0,0,0,8'h00,0,8'h00); #1;
    chk("R9 response overflow flagged", ovf_err, 1);
    chk("R7 still stalled", usr_rsp_vld, 0);
    @(negedge clk); #1;
    chk("R7 stall tail", usr_rsp_vld, 0);
    for (int k = 0; k < DEP; k++) begin
      @(negedge clk); #1;
      chk("R8 drain valid", usr_rsp_vld, 1);
      chk("R8,R9 drain order", usr_rsp_data, 8'h10 + k);
    end
    @(negedge clk); #1;
    chk("R9 dropped word absent", usr_rsp_vld, 0);

    do_reset(); #1;
    chk("R1 error cleared by reset", ovf_err, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule